// File: doc/BRIEF.md
# Line Watch and Wait Unit

This per-core block lets a thread watch one aligned coherence line and then pause instruction issue until something wakes it. An arm request carries an address and an extensions word. It records the line that holds the address and moves the unit from not armed to armed. A wait request carries an extensions word and a hints word. If the unit is armed and has not yet been triggered, the unit raises a stall output. While the stall is high, the unit shows the low-power target decoded from the hints. In every other case the wait request completes at once as a no-op.

The unit is triggered by any of these wake sources:
- a snooped coherence write that falls in the watched line;
- one of a fixed set of event strobes;
- a pending interrupt, subject to its mask and to the break-on-masked option of the current wait.

Requests with illegal extension words raise a general-protection flag and do not change the state. Requests made while the feature is disabled raise an undefined-opcode flag. When a wait ends, the unit drops back to not armed. Software must therefore re-arm the unit before it waits again.

Top module: `line_watch_unit`

## Requirements
- R1: After reset, `stall`, `wait_done`, `fault_gp` and `fault_ud` are 0, `pwr_cidx` and `pwr_sub` are 0, and the unit is not armed. A wait request at this point completes as a no-op.
- R2: An arm request is accepted when `feat_en` is 1, `arm_ext` is 0 and `stall` is 0. It records `arm_addr` and arms the unit. A later accepted wait request raises `stall` on the clock edge that samples it.
- R3: A snooped write (`snp_wr_vld`) triggers an armed unit when its address matches the recorded address in every bit above the low log2(LINE_BYTES) bits. With the default LINE_BYTES of 64, these are bits 47:6. A write to any other line has no effect.
- R4: Any bit of `wake_evt` triggers an armed unit. The bits are: 0 non-maskable interrupt, 1 system-management interrupt, 2 init, 3 machine check, 4 fault or abort, 5 translation invalidation or control-register write, 6 fast system call or far call.
- R5: When `irq_masked` is 0, `irq_pend` always triggers an armed unit. When `irq_masked` is 1, `irq_pend` triggers the unit only while a stall is in progress whose wait request had `wait_ext` bit 0 set.
- R6: An arm request with a nonzero `arm_ext` pulses `fault_gp` for one cycle and leaves the state and the recorded address unchanged.
- R7: A wait request on a unit that is not armed, or that is already triggered, pulses `wait_done` for one cycle and leaves `stall` at 0.
- R8: A wait request raises a one-cycle `fault_gp` and causes no stall and no `wait_done` in either of two cases: `wait_ext` has any bit above bit 0 set, or `wait_ext` bit 0 is set while `brk_cap` is 0. The state does not change.
- R9: While `stall` is 1, `pwr_sub` equals `wait_hint[3:0]`. `pwr_cidx` is 0 when `wait_hint[7:4]` is 4'hF (C0); otherwise it is `wait_hint[7:4]`+1, so field 0 gives C1 and field 1 gives C2. Hint bits above bit 7 are ignored. While `stall` is 0, both outputs are 0.
- R10: While `feat_en` is 0, an arm or wait request pulses `fault_ud` for one cycle and has no other effect.
- R11: Every wait that ends, whether by a wake or as a no-op, leaves the unit not armed.
- R12: A wake source sampled in the same cycle as an accepted arm request is applied after the arming, so the unit ends up triggered. A wake source sampled in the same cycle as a wait request on an armed unit makes that wait a no-op.
- R13: `stall` falls, and `wait_done` pulses, on the clock edge that samples the wake. Arm and wait requests made while `stall` is 1 are ignored and raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| feat_en | input | 1 | Feature enable; when 0, requests fault as undefined |
| brk_cap | input | 1 | Capability to break a wait on a masked interrupt |
| arm_req | input | 1 | Arm request strobe |
| arm_addr | input | ADDR_W | Address to watch |
| arm_ext | input | EXT_W | Arm extensions word; must be 0 |
| wait_req | input | 1 | Wait request strobe |
| wait_ext | input | EXT_W | Wait extensions word; bit 0 enables break on a masked interrupt |
| wait_hint | input | HINT_W | Wait hints; [7:4] target state, [3:0] sub-state |
| snp_wr_vld | input | 1 | Snooped coherence write valid |
| snp_wr_addr | input | ADDR_W | Snooped write address |
| wake_evt | input | N_EVT | Event wake strobes, bit order as in R4 |
| irq_pend | input | 1 | Interrupt pending |
| irq_masked | input | 1 | Pending interrupt is masked |
| stall | output | 1 | Hold instruction issue |
| wait_done | output | 1 | One-cycle pulse when a wait completes |
| fault_gp | output | 1 | One-cycle general-protection fault pulse |
| fault_ud | output | 1 | One-cycle undefined-opcode fault pulse |
| pwr_cidx | output | 4 | Target C-state index while stalled (0 = C0) |
| pwr_sub | output | 4 | Target sub-state while stalled |

## Verification
The assertions take for granted that the requesting pipeline never raises `arm_req` and `wait_req` in the same cycle. They also take for granted that requests come only after the synchronised reset has been released. Both are stated as checks of their own. The stimulus table drives at most one request per cycle. It starts only after several cycles have passed since reset was released, and it changes every input away from the active clock edge. Each wake source is presented only as a single-cycle strobe, so each assertion's trigger condition describes exactly one cycle.

// File: rtl/lwu_pkg.sv
package lwu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2
  } watch_state_e;

  localparam int unsigned EVT_NMI    = 0;
  localparam int unsigned EVT_SMI    = 1;
  localparam int unsigned EVT_INIT   = 2;
  localparam int unsigned EVT_MCHK   = 3;
  localparam int unsigned EVT_FAULT  = 4;
  localparam int unsigned EVT_TLBCR  = 5;
  localparam int unsigned EVT_FCALL  = 6;
  localparam int unsigned EVT_COUNT  = 7;

  localparam logic [3:0] CFIELD_C0 = 4'hF;

  typedef struct packed {
    logic [3:0] cidx;
    logic [3:0] sub;
  } pwr_tgt_t;

endpackage

// File: rtl/lwu_rst_sync.sv
module lwu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lwu_req_check.sv
module lwu_req_check #(
  parameter int unsigned EXT_W = 32
) (
  input  logic             feat_en,
  input  logic             brk_cap,
  input  logic             busy,
  input  logic             arm_req,
  input  logic [EXT_W-1:0] arm_ext,
  input  logic             wait_req,
  input  logic [EXT_W-1:0] wait_ext,
  output logic             arm_ok,
  output logic             wait_ok,
  output logic             wait_brk,
  output logic             gp_raise,
  output logic             ud_raise
);
  logic arm_seen, wait_seen;
  logic arm_bad, wait_bad;

  always_comb begin
    arm_seen  = arm_req  & ~busy;
    wait_seen = wait_req & ~busy;
    arm_bad   = |arm_ext;
    wait_bad  = (|wait_ext[EXT_W-1:1]) | (wait_ext[0] & ~brk_cap);

    ud_raise  = (arm_seen | wait_seen) & ~feat_en;
    gp_raise  = feat_en & ((arm_seen & arm_bad) | (wait_seen & wait_bad));
    arm_ok    = feat_en & arm_seen  & ~arm_bad;
    wait_ok   = feat_en & wait_seen & ~wait_bad;
    wait_brk  = wait_ext[0];
  end
endmodule

// File: rtl/lwu_wake_detect.sv
module lwu_wake_detect #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned N_EVT      = 7
) (
  input  logic              cmp_valid,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              snp_vld,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [N_EVT-1:0]  evt,
  input  logic              irq_pend,
  input  logic              irq_masked,
  input  logic              brk_en,
  output logic              wake
);
  localparam int unsigned OFS = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0;

  logic line_eq;

  generate
    if (OFS == 0) begin : g_byte
      assign line_eq = (cmp_addr == snp_addr);
    end else begin : g_line
      logic unused_ofs;
      assign line_eq    = (cmp_addr[ADDR_W-1:OFS] == snp_addr[ADDR_W-1:OFS]);
      assign unused_ofs = ^{cmp_addr[OFS-1:0], snp_addr[OFS-1:0]};
    end
  endgenerate

  logic snp_hit, evt_hit, irq_hit;

  always_comb begin
    snp_hit = snp_vld & cmp_valid & line_eq;
    evt_hit = |evt;
    irq_hit = irq_pend & (~irq_masked | brk_en);
    wake    = snp_hit | evt_hit | irq_hit;
  end
endmodule

// File: rtl/lwu_hint_decode.sv
module lwu_hint_decode
  import lwu_pkg::*;
(
  input  logic [7:0] hint_lo,
  output pwr_tgt_t   tgt
);
  logic [3:0] cfield;

  always_comb begin
    cfield   = hint_lo[7:4];
    tgt.sub  = hint_lo[3:0];
    tgt.cidx = (cfield == CFIELD_C0) ? 4'd0 : cfield + 4'd1;
  end
endmodule

// File: rtl/lwu_fsm.sv
module lwu_fsm
  import lwu_pkg::*;
#(
  parameter int unsigned ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_ok,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              wait_ok,
  input  logic              wait_brk,
  input  pwr_tgt_t          hint_tgt,
  input  logic              gp_raise,
  input  logic              ud_raise,
  input  logic              wake,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic              cmp_valid,
  output logic              brk_en,
  output watch_state_e      state,
  output logic              stall,
  output logic              done,
  output logic              gp,
  output logic              ud,
  output pwr_tgt_t          pwr
);
  watch_state_e      state_q, state_d;
  logic [ADDR_W-1:0] mon_q;
  logic              stall_q, stall_d;
  logic              brk_q, brk_d;
  logic              done_q, done_d;
  logic              gp_q, ud_q;
  pwr_tgt_t          pwr_q, pwr_d;
  logic              mon_en, pwr_en;

  always_comb begin
    cmp_addr  = arm_ok ? arm_addr : mon_q;
    cmp_valid = arm_ok | (state_q == ST_ARMED);
    brk_en    = stall_q & brk_q;
  end

  always_comb begin
    state_d = state_q;
    stall_d = stall_q;
    brk_d   = brk_q;
    pwr_d   = pwr_q;
    done_d  = 1'b0;
    mon_en  = arm_ok;
    pwr_en  = 1'b0;
    if (stall_q) begin
      if (wake) begin
        stall_d = 1'b0;
        brk_d   = 1'b0;
        state_d = ST_IDLE;
        done_d  = 1'b1;
        pwr_d   = '0;
        pwr_en  = 1'b1;
      end
    end else if (arm_ok) begin
      state_d = wake ? ST_TRIG : ST_ARMED;
    end else if (wait_ok) begin
      if ((state_q == ST_ARMED) && !wake) begin
        stall_d = 1'b1;
        brk_d   = wait_brk;
        pwr_d   = hint_tgt;
        pwr_en  = 1'b1;
      end else begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end else if ((state_q == ST_ARMED) && wake) begin
      state_d = ST_TRIG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stall_q <= 1'b0;
      brk_q   <= 1'b0;
      done_q  <= 1'b0;
      gp_q    <= 1'b0;
      ud_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      stall_q <= stall_d;
      brk_q   <= brk_d;
      done_q  <= done_d;
      gp_q    <= gp_raise;
      ud_q    <= ud_raise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_q <= '0;
    else if (pwr_en) pwr_q <= pwr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mon_q <= '0;
    else if (mon_en) mon_q <= arm_addr;
  end

  assign state = state_q;
  assign stall = stall_q;
  assign done  = done_q;
  assign gp    = gp_q;
  assign ud    = ud_q;
  assign pwr   = pwr_q;
endmodule

// File: rtl/line_watch_unit.sv
module line_watch_unit
  import lwu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned EXT_W      = 32,
  parameter int unsigned HINT_W     = 32,
  parameter int unsigned N_EVT      = EVT_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              brk_cap,
  input  logic              arm_req,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic [EXT_W-1:0]  arm_ext,
  input  logic              wait_req,
  input  logic [EXT_W-1:0]  wait_ext,
  input  logic [HINT_W-1:0] wait_hint,
  input  logic              snp_wr_vld,
  input  logic [ADDR_W-1:0] snp_wr_addr,
  input  logic [N_EVT-1:0]  wake_evt,
  input  logic              irq_pend,
  input  logic              irq_masked,
  output logic              stall,
  output logic              wait_done,
  output logic              fault_gp,
  output logic              fault_ud,
  output logic [3:0]        pwr_cidx,
  output logic [3:0]        pwr_sub
);
  logic              rst_sync_n;
  logic              arm_ok, wait_ok, wait_brk, gp_raise, ud_raise;
  logic              wake, brk_en, cmp_valid;
  logic [ADDR_W-1:0] cmp_addr;
  pwr_tgt_t          hint_tgt, pwr;
  watch_state_e      arm_state;
  logic              unused_hint;

  assign unused_hint = ^wait_hint[HINT_W-1:8];

  lwu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lwu_req_check #(.EXT_W(EXT_W)) u_req (
    .feat_en(feat_en), .brk_cap(brk_cap), .busy(stall),
    .arm_req(arm_req), .arm_ext(arm_ext),
    .wait_req(wait_req), .wait_ext(wait_ext),
    .arm_ok(arm_ok), .wait_ok(wait_ok), .wait_brk(wait_brk),
    .gp_raise(gp_raise), .ud_raise(ud_raise)
  );

  lwu_wake_detect #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .N_EVT(N_EVT)) u_wake (
    .cmp_valid(cmp_valid), .cmp_addr(cmp_addr),
    .snp_vld(snp_wr_vld), .snp_addr(snp_wr_addr),
    .evt(wake_evt), .irq_pend(irq_pend), .irq_masked(irq_masked),
    .brk_en(brk_en), .wake(wake)
  );

  lwu_hint_decode u_hint (
    .hint_lo(wait_hint[7:0]), .tgt(hint_tgt)
  );

  lwu_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .arm_ok(arm_ok), .arm_addr(arm_addr),
    .wait_ok(wait_ok), .wait_brk(wait_brk), .hint_tgt(hint_tgt),
    .gp_raise(gp_raise), .ud_raise(ud_raise), .wake(wake),
    .cmp_addr(cmp_addr), .cmp_valid(cmp_valid), .brk_en(brk_en),
    .state(arm_state), .stall(stall), .done(wait_done),
    .gp(fault_gp), .ud(fault_ud), .pwr(pwr)
  );

  assign pwr_cidx = pwr.cidx;
  assign pwr_sub  = pwr.sub;
endmodule

// File: rtl/lwu_checker.sv
module lwu_checker
  import lwu_pkg::*;
#(
  parameter int unsigned EXT_W = 32,
  parameter int unsigned N_EVT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             feat_en,
  input logic             brk_cap,
  input logic             arm_req,
  input logic [EXT_W-1:0] arm_ext,
  input logic             wait_req,
  input logic [EXT_W-1:0] wait_ext,
  input logic [N_EVT-1:0] wake_evt,
  input logic             irq_pend,
  input logic             irq_masked,
  input watch_state_e     arm_state,
  input logic             stall,
  input logic             wait_done,
  input logic             fault_gp,
  input logic             fault_ud,
  input logic [3:0]       pwr_cidx,
  input logic [3:0]       pwr_sub
);
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_req && wait_req)); // R2
  AST_UD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && (arm_req || wait_req) && !feat_en) |=> (fault_ud && !fault_gp && !wait_done)); // R10
  AST_ARM_EXT_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && arm_req && feat_en && (arm_ext != '0)) |=> (fault_gp && !stall)); // R6
  AST_WAIT_EXT_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && wait_req && feat_en && ((wait_ext[EXT_W-1:1] != '0) || (wait_ext[0] && !brk_cap)))
      |=> (fault_gp && !stall && !wait_done)); // R8
  AST_NOOP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && wait_req && feat_en && (wait_ext == '0) && (arm_state != ST_ARMED))
      |=> (wait_done && !stall)); // R7
  AST_EVT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (wake_evt != '0)) |=> (!stall && wait_done)); // R4
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && irq_pend && !irq_masked) |=> (!stall && wait_done)); // R5
  AST_IDLE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (pwr_cidx == 4'd0 && pwr_sub == 4'd0)); // R9
  AST_END_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> (arm_state == ST_IDLE && !stall)); // R11
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!fault_gp && !fault_ud)); // R13
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_gp, fault_ud, wait_done})); // R10
endmodule

bind line_watch_unit lwu_checker #(.EXT_W(EXT_W), .N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .feat_en(feat_en), .brk_cap(brk_cap),
  .arm_req(arm_req), .arm_ext(arm_ext), .wait_req(wait_req), .wait_ext(wait_ext),
  .wake_evt(wake_evt), .irq_pend(irq_pend), .irq_masked(irq_masked),
  .arm_state(arm_state), .stall(stall), .wait_done(wait_done),
  .fault_gp(fault_gp), .fault_ud(fault_ud), .pwr_cidx(pwr_cidx), .pwr_sub(pwr_sub)
);

// File: tb/sim_line_watch_unit.sv
module sim_line_watch_unit;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned EXT_W  = 32;
  localparam int unsigned HINT_W = 32;
  localparam int unsigned N_EVT  = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              feat_en, brk_cap, arm_req, wait_req, snp_wr_vld, irq_pend, irq_masked;
  logic [ADDR_W-1:0] arm_addr, snp_wr_addr;
  logic [EXT_W-1:0]  arm_ext, wait_ext;
  logic [HINT_W-1:0] wait_hint;
  logic [N_EVT-1:0]  wake_evt;
  logic              stall, wait_done, fault_gp, fault_ud;
  logic [3:0]        pwr_cidx, pwr_sub;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_watch_unit u0 (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .brk_cap(brk_cap),
    .arm_req(arm_req), .arm_addr(arm_addr), .arm_ext(arm_ext),
    .wait_req(wait_req), .wait_ext(wait_ext), .wait_hint(wait_hint),
    .snp_wr_vld(snp_wr_vld), .snp_wr_addr(snp_wr_addr), .wake_evt(wake_evt),
    .irq_pend(irq_pend), .irq_masked(irq_masked),
    .stall(stall), .wait_done(wait_done), .fault_gp(fault_gp), .fault_ud(fault_ud),
    .pwr_cidx(pwr_cidx), .pwr_sub(pwr_sub)
  );

  // op: 0 none, 1 arm, 2 wait
  typedef struct packed {
    logic [1:0]  op;
    logic        fe;
    logic        cap;
    logic [15:0] addr;
    logic [7:0]  ext;
    logic [7:0]  hint;
    logic        sv;
    logic [15:0] sa;
    logic [6:0]  evt;
    logic        ip;
    logic        im;
    logic        e_st;
    logic        e_dn;
    logic        e_gp;
    logic        e_ud;
    logic [3:0]  e_ci;
    logic [3:0]  e_sb;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd1},  // R1 idle
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd7},  // R7 unarmed wait
    '{2'd1,1'b1,1'b1,16'h1000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd2},  // R2 arm
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h21,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'd3,4'd1,8'd2},  // R2 stall, C3.1
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b1,16'h1040,7'h00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'd3,4'd1,8'd3},  // R3 other line
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b1,16'h103F,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd3},  // R3 same line
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd11}, // R11
    '{2'd1,1'b1,1'b1,16'h2000,8'h01,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,4'd0,4'd0,8'd6},  // R6
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd6},  // R6 still unarmed
    '{2'd1,1'b1,1'b1,16'h2000,8'h00,8'h00,1'b0,16'h0000,7'h04,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd12}, // R12 arm+evt
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h10,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd12}, // R12 noop
    '{2'd1,1'b1,1'b1,16'h3000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd2},  // R2
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd5},  // R5 masked, no wait
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'hF3,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'd0,4'd3,8'd9},  // R9 C0
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,4'd0,4'd3,8'd5},  // R5 masked, no break
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h40,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd4},  // R4 bit6
    '{2'd1,1'b1,1'b1,16'h4000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd2},  // R2
    '{2'd2,1'b1,1'b0,16'h0000,8'h01,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,4'd0,4'd0,8'd8},  // R8 no cap
    '{2'd2,1'b1,1'b1,16'h0000,8'h02,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,4'd0,4'd0,8'd8},  // R8 high bit
    '{2'd2,1'b1,1'b1,16'h0000,8'h01,8'hE7,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'd15,4'd7,8'd9}, // R9 C15
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd5},  // R5 masked break
    '{2'd1,1'b0,1'b1,16'h5000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,4'd0,4'd0,8'd10}, // R10 arm
    '{2'd2,1'b0,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,4'd0,4'd0,8'd10}, // R10 wait
    '{2'd1,1'b1,1'b1,16'h5000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd2},  // R2
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd5},  // R5 unmasked
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h30,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd7},  // R7 triggered
    '{2'd1,1'b1,1'b1,16'h6000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd2},  // R2
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h30,1'b1,16'h6008,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd12}, // R12 wait+snoop
    '{2'd1,1'b1,1'b1,16'h7000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd2},  // R2
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h01,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd4},  // R4 bit0
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd4},  // R4 noop
    '{2'd1,1'b1,1'b1,16'h8000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd2},  // R2
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h45,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'd5,4'd5,8'd9},  // R9 C5.5
    '{2'd1,1'b1,1'b1,16'h9000,8'h01,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'd5,4'd5,8'd13}, // R13 arm ignored
    '{2'd2,1'b0,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'd5,4'd5,8'd13}, // R13 wait ignored
    '{2'd0,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b1,16'h8010,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd13}, // R13 wake
    '{2'd2,1'b1,1'b1,16'h0000,8'h00,8'h00,1'b0,16'h0000,7'h00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,8'd13}  // R13 arm was dropped
  };

  task automatic idle_inputs();
    feat_en = 1'b1; brk_cap = 1'b1; arm_req = 1'b0; wait_req = 1'b0;
    arm_addr = '0; arm_ext = '0; wait_ext = '0; wait_hint = '0;
    snp_wr_vld = 1'b0; snp_wr_addr = '0; wake_evt = '0;
    irq_pend = 1'b0; irq_masked = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    feat_en     = v.fe;
    brk_cap     = v.cap;
    arm_req     = (v.op == 2'd1);
    wait_req    = (v.op == 2'd2);
    arm_addr    = {{(ADDR_W-16){1'b0}}, v.addr};
    arm_ext     = {{(EXT_W-8){1'b0}}, v.ext};
    wait_ext    = {{(EXT_W-8){1'b0}}, v.ext};
    wait_hint   = {{(HINT_W-8){1'b0}}, v.hint};
    snp_wr_vld  = v.sv;
    snp_wr_addr = {{(ADDR_W-16){1'b0}}, v.sa};
    wake_evt    = v.evt;
    irq_pend    = v.ip;
    irq_masked  = v.im;
  endtask

  task automatic check(input int rq, input logic [11:0] exp);
    logic [11:0] act;
    act = {stall, wait_done, fault_gp, fault_ud, pwr_cidx, pwr_sub};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: {stall,done,gp,ud,cidx,sub} actual %b_%b_%b_%b_%h_%h expected %b_%b_%b_%b_%h_%h",
               rq, act[11], act[10], act[9], act[8], act[7:4], act[3:0],
               exp[11], exp[10], exp[9], exp[8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 12'h000);  // R1 outputs held in reset
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(1, 12'h000);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check(int'(TBL[i].rq),
            {TBL[i].e_st, TBL[i].e_dn, TBL[i].e_gp, TBL[i].e_ud, TBL[i].e_ci, TBL[i].e_sb});
    end

    // R3: upper address bits take part in the line compare; R9: hint bits above 7 ignored
    idle_inputs();
    arm_req = 1'b1; arm_addr = 48'h0100_0000_1000;
    @(negedge clk);
    idle_inputs();
    wait_req = 1'b1; wait_hint = 32'hFFFF_FF12;
    @(negedge clk);
    check(9, {4'b1000, 4'd2, 4'd2});
    idle_inputs();
    snp_wr_vld = 1'b1; snp_wr_addr = 48'h0000_0000_1000;
    @(negedge clk);
    check(3, {4'b1000, 4'd2, 4'd2});
    idle_inputs();
    snp_wr_vld = 1'b1; snp_wr_addr = 48'h0100_0000_1020;
    @(negedge clk);
    check(3, {4'b0100, 4'd0, 4'd0});
    idle_inputs();
    @(negedge clk);
    check(13, 12'h000);  // R13 wake pulse lasts one cycle

    // R4: each event line wakes a stall
    for (int b = 0; b < N_EVT; b++) begin
      idle_inputs();
      arm_req = 1'b1; arm_addr = 48'h0000_0000_A000;
      @(negedge clk);
      idle_inputs();
      wait_req = 1'b1; wait_hint = 32'h0000_0000;
      @(negedge clk);
      check(4, {4'b1000, 4'd1, 4'd0});
      idle_inputs();
      wake_evt = N_EVT'(1) << b;
      @(negedge clk);
      check(4, {4'b0100, 4'd0, 4'd0});
    end

    // R1: reset during a stall returns to not armed
    idle_inputs();
    arm_req = 1'b1; arm_addr = 48'h0000_0000_B000;
    @(negedge clk);
    idle_inputs();
    wait_req = 1'b1; wait_hint = 32'h0000_0022;
    @(negedge clk);
    check(2, {4'b1000, 4'd3, 4'd2});
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check(1, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    wait_req = 1'b1;
    @(negedge clk);
    check(1, {4'b0100, 4'd0, 4'd0});
    idle_inputs();
    @(negedge clk);

    finish_run();
  end
endmodule